// File: doc/BRIEF.md
# Compressed Associative Branch Target Buffer

This block predicts the destination of a branch from the fetch address alone. A lookup presents the fetch PC and receives, in the same cycle, a hit flag and a predicted target. It is a set-associative array indexed by word-address bits of the PC. Each set holds three compact ways and one wide way. A compact way keeps only the low 16 bits of the target and takes the rest from the lookup PC. The wide way keeps the whole target, for branches whose destination lies outside the 64 KiB region of the branch itself.

Training comes from the execute side. Each training update carries the branch PC, the resolved target and a taken flag. The update first goes through a pipeline register and is written into the array one cycle after it is presented. A taken update installs or refreshes the entry. A not-taken update removes a matching entry. New compact entries replace older ones in rotating order within their set. A wide entry always displaces the set's single wide slot.

Top module: `cbtb_top`

## Requirements
- R1: After reset every lookup misses (lk_hit is 0) until a taken update has been written.
- R2: A training update presented at clock edge k is written at edge k+1. A lookup between those edges sees the old contents, and a lookup after edge k+1 sees the new ones.
- R3: A branch whose target shares bits [31:16] with its PC is stored in a compact way. A hit on a compact way returns {lookup PC[31:16], stored low 16 bits}.
- R4: A branch whose target differs from its PC in bits [31:16] is stored in the wide way, and a hit on it returns all 32 target bits.
- R5: Each set has exactly one wide way. A second wide-target branch in the same set replaces the first, and the first then misses.
- R6: New compact entries go into ways 0, 1, 2, 0, ... of their set, following a per-set rotating pointer, so the fourth distinct compact branch in a set evicts the first.
- R7: A taken update whose PC already hits rewrites that entry in place. It does not advance the rotating pointer and does not evict other entries.
- R8: A not-taken update whose PC hits invalidates that entry and leaves the other entries of the set intact.
- R9: A not-taken update whose PC misses changes nothing.
- R10: The set index is PC[5:2] and the tag is PC[31:6]. PC[1:0] is ignored, and a PC with a different tag in the same set misses.
- R11: At most one way of a set matches a given PC at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_target | output | 32 | Predicted target, valid when lk_hit is 1 |
| tr_valid | input | 1 | Training update present this cycle |
| tr_pc | input | 32 | PC of the resolved branch |
| tr_target | input | 32 | Resolved branch target |
| tr_taken | input | 1 | Branch was taken (1) or not taken (0) |

## Verification
The assertions check four things on every cycle. Each update reaches the write stage exactly one cycle later. No PC ever matches two ways. A compact hit returns the upper bits of the lookup PC. The rotating pointer of the set being written never leaves the range of compact ways. The bench scenarios cover what only a sequence of updates can show: the order of eviction within a set, in-place rewrite without eviction, invalidation by not-taken updates, replacement of the wide slot, and the one-cycle window in which a lookup still sees the old contents.

// File: rtl/cbtb_pkg.sv
package cbtb_pkg;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 4;
  localparam int LOW_W  = 16;
  localparam int NCWAY  = 3;
  localparam int TAG_W  = PC_W - IDX_W - 2;

  function automatic logic [IDX_W-1:0] set_of(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:IDX_W+2];
  endfunction

  function automatic logic fits_compact(input logic [PC_W-1:0] pc,
                                        input logic [PC_W-1:0] tgt);
    return pc[PC_W-1:LOW_W] == tgt[PC_W-1:LOW_W];
  endfunction

  function automatic logic [PC_W-1:0] expand(input logic [PC_W-1:0] pc,
                                             input logic [LOW_W-1:0] low);
    return {pc[PC_W-1:LOW_W], low};
  endfunction
endpackage

// File: rtl/cbtb_train_reg.sv
module cbtb_train_reg
  import cbtb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  logic [PC_W-1:0] in_tgt,
  input  logic            in_taken,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output logic [PC_W-1:0] q_tgt,
  output logic            q_taken
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_tgt   <= '0;
      q_taken <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_pc    <= in_pc;
      q_tgt   <= in_tgt;
      q_taken <= in_taken;
    end
  end

  p_train_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (q_valid && q_pc == $past(in_pc) && q_tgt == $past(in_tgt)));
endmodule

// File: rtl/cbtb_store.sv
module cbtb_store
  import cbtb_pkg::*;
#(
  parameter int NSETS = 1 << IDX_W,
  parameter int NC    = NCWAY
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       w_valid,
  input  logic [PC_W-1:0]            w_pc,
  input  logic [PC_W-1:0]            w_tgt,
  input  logic                       w_taken,
  input  logic [IDX_W-1:0]           r_set,
  output logic [NC-1:0]              r_cval,
  output logic [NC-1:0][TAG_W-1:0]   r_ctag,
  output logic [NC-1:0][LOW_W-1:0]   r_clow,
  output logic                       r_fval,
  output logic [TAG_W-1:0]           r_ftag,
  output logic [PC_W-1:0]            r_ftgt
);
  localparam int PTR_W = (NC > 1) ? $clog2(NC) : 1;

  logic [NSETS-1:0]             cval [NC];
  logic [TAG_W-1:0]             ctag [NC][NSETS];
  logic [LOW_W-1:0]             clow [NC][NSETS];
  logic [NSETS-1:0]             fval;
  logic [TAG_W-1:0]             ftag [NSETS];
  logic [PC_W-1:0]              ftgt [NSETS];
  logic [PTR_W-1:0]             rr   [NSETS];

  // named update events
  logic [IDX_W-1:0] w_set;
  logic [TAG_W-1:0] w_tag;
  logic [NC-1:0]    w_chit;
  logic             w_fhit;
  logic             w_comp;
  logic             ev_kill, ev_refresh, ev_install, ev_wide;
  logic [PTR_W-1:0] rr_cur, rr_nxt;

  assign w_set  = set_of(w_pc);
  assign w_tag  = tag_of(w_pc);
  assign w_comp = fits_compact(w_pc, w_tgt);
  assign w_fhit = fval[w_set] && ftag[w_set] == w_tag;
  assign rr_cur = rr[w_set];
  assign rr_nxt = (rr_cur == PTR_W'(NC-1)) ? '0 : rr_cur + 1'b1;

  for (genvar w = 0; w < NC; w++) begin : g_hit
    assign w_chit[w] = cval[w][w_set] && ctag[w][w_set] == w_tag;
    assign r_cval[w] = cval[w][r_set];
    assign r_ctag[w] = ctag[w][r_set];
    assign r_clow[w] = clow[w][r_set];
  end
  assign r_fval = fval[r_set];
  assign r_ftag = ftag[r_set];
  assign r_ftgt = ftgt[r_set];

  assign ev_kill    = w_valid && !w_taken;
  assign ev_refresh = w_valid && w_taken && w_comp && (|w_chit);
  assign ev_install = w_valid && w_taken && w_comp && !(|w_chit);
  assign ev_wide    = w_valid && w_taken && !w_comp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NC; w++) cval[w] <= '0;
      fval <= '0;
      for (int s = 0; s < NSETS; s++) rr[s] <= '0;
    end else begin
      if (ev_kill) begin
        for (int w = 0; w < NC; w++) if (w_chit[w]) cval[w][w_set] <= 1'b0;
        if (w_fhit) fval[w_set] <= 1'b0;
      end
      if (ev_refresh) begin
        for (int w = 0; w < NC; w++) if (w_chit[w]) clow[w][w_set] <= w_tgt[LOW_W-1:0];
      end
      if (ev_install) begin
        for (int w = 0; w < NC; w++) begin
          if (rr_cur == PTR_W'(w)) begin
            cval[w][w_set] <= 1'b1;
            ctag[w][w_set] <= w_tag;
            clow[w][w_set] <= w_tgt[LOW_W-1:0];
          end
        end
        rr[w_set] <= rr_nxt;
        if (w_fhit) fval[w_set] <= 1'b0;
      end
      if (ev_wide) begin
        fval[w_set] <= 1'b1;
        ftag[w_set] <= w_tag;
        ftgt[w_set] <= w_tgt;
        for (int w = 0; w < NC; w++) if (w_chit[w]) cval[w][w_set] <= 1'b0;
      end
    end
  end

  p_rr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rr_cur < PTR_W'(NC));
  p_upd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({w_chit, w_fhit}));
  p_install_pointer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_install |=> (rr[$past(w_set)] == $past(rr_nxt)));
endmodule

// File: rtl/cbtb_lookup.sv
module cbtb_lookup
  import cbtb_pkg::*;
#(
  parameter int NC = NCWAY
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PC_W-1:0]          pc,
  input  logic [NC-1:0]            cval,
  input  logic [NC-1:0][TAG_W-1:0] ctag,
  input  logic [NC-1:0][LOW_W-1:0] clow,
  input  logic                     fval,
  input  logic [TAG_W-1:0]         ftag,
  input  logic [PC_W-1:0]          ftgt,
  output logic                     hit,
  output logic [PC_W-1:0]          target
);
  logic [TAG_W-1:0] t;
  logic [NC-1:0]    chit;
  logic             fhit;

  assign t    = tag_of(pc);
  assign fhit = fval && ftag == t;
  for (genvar w = 0; w < NC; w++) begin : g_cmp
    assign chit[w] = cval[w] && ctag[w] == t;
  end

  always_comb begin
    hit    = fhit | (|chit);
    target = fhit ? ftgt : '0;
    for (int w = 0; w < NC; w++) begin
      if (!fhit && chit[w]) target = expand(pc, clow[w]);
    end
  end

  p_single_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chit, fhit}));
  p_compact_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fhit) |-> target[PC_W-1:LOW_W] == pc[PC_W-1:LOW_W]);
endmodule

// File: rtl/cbtb_top.sv
module cbtb_top
  import cbtb_pkg::*;
#(
  parameter int NSETS = 1 << IDX_W,
  parameter int NC    = NCWAY
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  input  logic            tr_valid,
  input  logic [PC_W-1:0] tr_pc,
  input  logic [PC_W-1:0] tr_target,
  input  logic            tr_taken
);
  logic                     q_valid, q_taken;
  logic [PC_W-1:0]          q_pc, q_tgt;
  logic [NC-1:0]            r_cval;
  logic [NC-1:0][TAG_W-1:0] r_ctag;
  logic [NC-1:0][LOW_W-1:0] r_clow;
  logic                     r_fval;
  logic [TAG_W-1:0]         r_ftag;
  logic [PC_W-1:0]          r_ftgt;

  cbtb_train_reg u_treg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tr_valid), .in_pc(tr_pc), .in_tgt(tr_target), .in_taken(tr_taken),
    .q_valid(q_valid), .q_pc(q_pc), .q_tgt(q_tgt), .q_taken(q_taken)
  );

  cbtb_store #(.NSETS(NSETS), .NC(NC)) u_store (
    .clk(clk), .rst_n(rst_n),
    .w_valid(q_valid), .w_pc(q_pc), .w_tgt(q_tgt), .w_taken(q_taken),
    .r_set(set_of(lk_pc)),
    .r_cval(r_cval), .r_ctag(r_ctag), .r_clow(r_clow),
    .r_fval(r_fval), .r_ftag(r_ftag), .r_ftgt(r_ftgt)
  );

  cbtb_lookup #(.NC(NC)) u_lookup (
    .clk(clk), .rst_n(rst_n), .pc(lk_pc),
    .cval(r_cval), .ctag(r_ctag), .clow(r_clow),
    .fval(r_fval), .ftag(r_ftag), .ftgt(r_ftgt),
    .hit(lk_hit), .target(lk_target)
  );
endmodule

// File: tb/cbtb_top_tb_top.sv
module cbtb_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        do_tr;
    logic [31:0] tpc;
    logic [31:0] ttgt;
    logic        tkn;
    logic [31:0] lpc;
    logic        ehit;
    logic [31:0] etgt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h0000_1004, 32'h0000_2000, 1'b1, 32'h0000_1004, 1'b1, 32'h0000_2000, 8'd3},  // R3
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1044, 1'b0, 32'h0, 8'd10},                        // R10
    '{1'b1, 32'h0001_0008, 32'h8000_0000, 1'b1, 32'h0001_0008, 1'b1, 32'h8000_0000, 8'd4},  // R4
    '{1'b1, 32'h0002_0008, 32'h9000_0000, 1'b1, 32'h0001_0008, 1'b0, 32'h0, 8'd5},          // R5
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0002_0008, 1'b1, 32'h9000_0000, 8'd5},                  // R5
    '{1'b1, 32'h0000_100C, 32'h0000_3000, 1'b1, 32'h0000_100C, 1'b1, 32'h0000_3000, 8'd6},  // R6
    '{1'b1, 32'h0000_104C, 32'h0000_3100, 1'b1, 32'h0000_104C, 1'b1, 32'h0000_3100, 8'd6},  // R6
    '{1'b1, 32'h0000_108C, 32'h0000_3200, 1'b1, 32'h0000_100C, 1'b1, 32'h0000_3000, 8'd6},  // R6
    '{1'b1, 32'h0000_10CC, 32'h0000_3300, 1'b1, 32'h0000_100C, 1'b0, 32'h0, 8'd6},          // R6
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_104C, 1'b1, 32'h0000_3100, 8'd6},                  // R6
    '{1'b1, 32'h0000_104C, 32'h0000_3500, 1'b1, 32'h0000_104C, 1'b1, 32'h0000_3500, 8'd7},  // R7
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_108C, 1'b1, 32'h0000_3200, 8'd7},                  // R7
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_10CC, 1'b1, 32'h0000_3300, 8'd7},                  // R7
    '{1'b1, 32'h0000_104C, 32'h0000_3500, 1'b0, 32'h0000_104C, 1'b0, 32'h0, 8'd8},          // R8
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_108C, 1'b1, 32'h0000_3200, 8'd8},                  // R8
    '{1'b1, 32'h0000_200C, 32'h0000_2100, 1'b0, 32'h0000_200C, 1'b0, 32'h0, 8'd9},          // R9
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_10CC, 1'b1, 32'h0000_3300, 8'd9},                  // R9
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1006, 1'b1, 32'h0000_2000, 8'd10},                 // R10
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1008, 1'b0, 32'h0, 8'd10}                          // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_hit;
  logic [31:0] lk_target;
  logic        tr_valid = 1'b0;
  logic [31:0] tr_pc = '0;
  logic [31:0] tr_target = '0;
  logic        tr_taken = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbtb_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_target(tr_target), .tr_taken(tr_taken)
  );

  task automatic check(input int req, input logic ehit, input logic [31:0] etgt);
    n_run++;
    if (lk_hit !== ehit || (ehit && lk_target !== etgt)) begin
      n_fail++;
      $display("FAIL R%0d pc=%h: hit=%b target=%h expected hit=%b target=%h",
               req, lk_pc, lk_hit, lk_target, ehit, etgt);
    end
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] tgt, input logic tkn);
    @(negedge clk);
    tr_valid = 1'b1; tr_pc = pc; tr_target = tgt; tr_taken = tkn;
    @(negedge clk);
    tr_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: empty after reset
    lk_pc = 32'h0000_1004; #1 check(1, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    lk_pc = 32'h0002_0008; #1 check(1, 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].do_tr) train(TBL[i].tpc, TBL[i].ttgt, TBL[i].tkn);
      else @(negedge clk);
      lk_pc = TBL[i].lpc;
      #1 check(int'(TBL[i].req), TBL[i].ehit, TBL[i].etgt);
    end

    // R2: old contents visible in the cycle between capture and write
    @(negedge clk);
    tr_valid = 1'b1; tr_pc = 32'h0000_1010; tr_target = 32'h0000_4000; tr_taken = 1'b1;
    lk_pc = 32'h0000_1010;
    @(negedge clk);
    tr_valid = 1'b0;
    #1 check(2, 1'b0, '0);
    @(negedge clk);
    #1 check(2, 1'b1, 32'h0000_4000);

    // R4: wide hit in set 4 returns all 32 bits
    train(32'h0000_1010, 32'hABCD_0010, 1'b1);
    lk_pc = 32'h0000_1010; #1 check(4, 1'b1, 32'hABCD_0010);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule